// File: doc/BRIEF.md
# Ten-bit colour seven-slot link packer

This block turns one 30-bit colour pixel (ten bits each of red, green and blue) and the three video control flags into the five data-lane words of a seven-to-one differential video link. It also builds the clock-lane word. Every pixel period holds seven bit slots per lane. A per-pixel format input picks one of two bit orderings. In the low-first ordering, the least significant six bits of each colour travel on the first three lanes. In the high-first ordering, the most significant six bits take those places. The remaining bit pairs move onto the fourth and fifth lanes.

The block runs on the bit-rate clock. It keeps its own slot counter and raises a one-cycle strobe in the last slot of every frame. On the clock edge that ends that cycle it captures the pixel inputs and the format input. The captured words are presented in parallel for an external serializer. When the serializer option is built, a rotating register per lane also presents them one bit per clock, slot 0 first, together with a clock-lane bit. The analog drivers and the bit-clock PLL lie outside the block.

Top module: `lvds10_packer`

## Requirements
- R1: `pix_load` is high for exactly one clock in every seven, in slot 6. Pixel, control and format inputs are captured only on the rising edge that ends a `pix_load` cycle. Values they hold in any other cycle have no effect on any output.
- R2: With `fmt_hi_first` = 0, lane 0 slots 0..5 carry red bits 0..5 and slot 6 carries green bit 0. Lane 1 slots 0..4 carry green bits 1..5, and slots 5 and 6 carry blue bits 0 and 1. Lane 2 slots 0..3 carry blue bits 2..5.
- R3: With `fmt_hi_first` = 0, lane 3 slots 0..5 carry red 6, red 7, green 6, green 7, blue 6 and blue 7. Lane 4 slots 0..5 carry the same pattern with bits 8 and 9.
- R4: With `fmt_hi_first` = 1, every slot named in R2 and R3 carries a different bit of the same colour. Position p in 0..5 carries colour bit p+4, positions 6 and 7 carry bits 2 and 3, and positions 8 and 9 carry bits 0 and 1.
- R5: In both orderings, lane 2 slots 4, 5 and 6 carry `pix_hs`, `pix_vs` and `pix_de`.
- R6: Slot 6 of lanes 3 and 4 is always 0, on the parallel words and on the serial outputs.
- R7: `lane_word` holds lane i at bits [7i+6:7i], with slot s at bit 7i+s. In the k-th clock after a capture edge (k = 0..6), `ser_data[i]` equals slot k of lane i.
- R8: `ser_clk` follows 1,1,0,0,0,1,1 over slots 0..6 of every frame.
- R9: While `rst_n` is low, `lane_word` and `ser_data` are 0, `ser_clk` is 1 and `pix_load` is 0. The first clock after reset is slot 0, so the first `pix_load` comes six clocks after release.
- R10: The format captured with a pixel applies to that whole frame. After deserializing and undoing the chosen ordering, every colour bit returns to its original position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (seven per pixel) |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_hi_first | input | 1 | 0: low-first ordering (default), 1: high-first ordering |
| pix_r | input | 10 | Red value |
| pix_g | input | 10 | Green value |
| pix_b | input | 10 | Blue value |
| pix_hs | input | 1 | Horizontal sync flag |
| pix_vs | input | 1 | Vertical sync flag |
| pix_de | input | 1 | Data enable flag |
| pix_load | output | 1 | Slot-6 strobe; inputs are taken at the end of this cycle |
| lane_word | output | 35 | Captured lane words, five lanes of seven slots |
| ser_data | output | 5 | Serial data lanes, one slot per clock |
| ser_clk | output | 1 | Serial clock-lane bit |

## Verification
On every cycle the in-line properties check several things: the strobe spacing, the agreement of each serial lane with its parallel word at the current slot, the clock-lane pattern, the zero in the reserved slots, and the capture of the control flags into lane 2. Only the bench's scenarios show that each colour bit lands in the slot the chosen ordering gives it. They also show that values changed between strobes are ignored, that a format switch takes effect exactly at a frame boundary, and that a full serial frame decodes back to the original pixel in both orderings.

// File: rtl/lvdp_pkg.sv
package lvdp_pkg;
   localparam int unsigned SLOT_N  = 7;
   localparam int unsigned LANE_N  = 5;
   localparam int unsigned COLOR_W = 10;
   // clock-lane level per slot, bit s = slot s
   localparam logic [SLOT_N-1:0] CLK_PATTERN = 7'b1100011;
   typedef logic [SLOT_N-1:0]  slot_word_t;
   typedef logic [COLOR_W-1:0] color_t;
endpackage

// File: rtl/lvdp_order.sv
// Reorders one colour so that the lane map can place bits with a single layout.
module lvdp_order #(
   parameter int unsigned COLOR_W = 10,
   parameter int unsigned PAIR_W  = 2
) (
   input  logic               hi_first,
   input  logic [COLOR_W-1:0] c_in,
   output logic [COLOR_W-1:0] c_out
);
   localparam int unsigned LOW_W = COLOR_W - 2*PAIR_W;

   initial begin
      assert (LOW_W > 0) else $fatal(1, "lvdp_order: colour too narrow");
   end

   logic [COLOR_W-1:0] swapped;
   // position p<LOW_W takes bit p+2*PAIR_W; middle pair takes the second pair; top pair takes the lowest
   assign swapped = {c_in[PAIR_W-1:0], c_in[2*PAIR_W-1:PAIR_W], c_in[COLOR_W-1:2*PAIR_W]};
   assign c_out   = hi_first ? swapped : c_in;
endmodule

// File: rtl/lvdp_lane_map.sv
// Places ordered colour bits and control flags into the five lane words.
module lvdp_lane_map
   import lvdp_pkg::*;
(
   input  color_t                        r,
   input  color_t                        g,
   input  color_t                        b,
   input  logic                          hs,
   input  logic                          vs,
   input  logic                          de,
   output logic [LANE_N-1:0][SLOT_N-1:0] words
);
   always_comb begin
      words[0] = {g[0], r[5:0]};
      words[1] = {b[1], b[0], g[5:1]};
      words[2] = {de, vs, hs, b[5:2]};
      words[3] = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
      words[4] = {1'b0, b[9], b[8], g[9], g[8], r[9], r[8]};
   end
endmodule

// File: rtl/lvdp_shifter.sv
// One lane of the serializer: parallel load at the frame boundary, rotate otherwise.
module lvdp_shifter #(
   parameter int unsigned       SLOT_N  = 7,
   parameter logic [SLOT_N-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SLOT_N-1:0] din,
   output logic              dout
);
   logic [SLOT_N-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sh_q <= RST_VAL;
      else if (load)
         sh_q <= din;
      else
         sh_q <= {sh_q[0], sh_q[SLOT_N-1:1]};
   end

   assign dout = sh_q[0];
endmodule

// File: rtl/lvds10_packer.sv
module lvds10_packer #(
   parameter int unsigned COLOR_W   = 10,
   parameter int unsigned SLOT_N    = 7,
   parameter int unsigned LANE_N    = 5,
   parameter bit          SERIAL_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fmt_hi_first,
   input  logic [COLOR_W-1:0]         pix_r,
   input  logic [COLOR_W-1:0]         pix_g,
   input  logic [COLOR_W-1:0]         pix_b,
   input  logic                       pix_hs,
   input  logic                       pix_vs,
   input  logic                       pix_de,
   output logic                       pix_load,
   output logic [LANE_N*SLOT_N-1:0]   lane_word,
   output logic [LANE_N-1:0]          ser_data,
   output logic                       ser_clk
);
   import lvdp_pkg::*;

   localparam int unsigned CNT_W = $clog2(SLOT_N);
   localparam int unsigned LAST  = SLOT_N - 1;
   localparam int unsigned NCOL  = 3;

   initial begin
      assert (COLOR_W == lvdp_pkg::COLOR_W) else $fatal(1, "lvds10_packer: COLOR_W must be 10");
      assert (SLOT_N == lvdp_pkg::SLOT_N) else $fatal(1, "lvds10_packer: SLOT_N must be 7");
      assert (LANE_N == lvdp_pkg::LANE_N) else $fatal(1, "lvds10_packer: LANE_N must be 5");
   end

   // slot counter and frame strobe
   logic [CNT_W-1:0] cnt;

   assign pix_load = (cnt == CNT_W'(LAST));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (pix_load)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // colour ordering, one instance per primary
   logic [NCOL-1:0][COLOR_W-1:0] col_in;
   logic [NCOL-1:0][COLOR_W-1:0] col_ord;

   assign col_in = {pix_b, pix_g, pix_r};

   for (genvar k = 0; k < NCOL; k++) begin : g_order
      lvdp_order #(.COLOR_W(COLOR_W), .PAIR_W(2)) i_order (
         .hi_first (fmt_hi_first),
         .c_in     (col_in[k]),
         .c_out    (col_ord[k])
      );
   end

   // lane placement and capture register
   logic [LANE_N-1:0][SLOT_N-1:0] words_d;
   logic [LANE_N-1:0][SLOT_N-1:0] word_q;

   lvdp_lane_map i_map (
      .r     (col_ord[0]),
      .g     (col_ord[1]),
      .b     (col_ord[2]),
      .hs    (pix_hs),
      .vs    (pix_vs),
      .de    (pix_de),
      .words (words_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         word_q <= '0;
      else if (pix_load)
         word_q <= words_d;
   end

   for (genvar i = 0; i < LANE_N; i++) begin : g_flat
      assign lane_word[i*SLOT_N +: SLOT_N] = word_q[i];
   end

   // R1
   load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_load |=> !pix_load);

   // R1
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_load |=> (cnt == '0));

   // R5
   ctl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_load |=> (lane_word[2*SLOT_N+LAST -: 3] == $past({pix_de, pix_vs, pix_hs})));

   // optional serializer
   if (SERIAL_EN) begin : g_ser
      for (genvar i = 0; i < LANE_N; i++) begin : g_lane
         lvdp_shifter #(.SLOT_N(SLOT_N), .RST_VAL('0)) i_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (pix_load),
            .din   (words_d[i]),
            .dout  (ser_data[i])
         );

         // R7
         ser_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ser_data[i] == lane_word[i*SLOT_N + int'(cnt)]);
      end

      lvdp_shifter #(.SLOT_N(SLOT_N), .RST_VAL(CLK_PATTERN)) i_clk_shift (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (pix_load),
         .din   (CLK_PATTERN),
         .dout  (ser_clk)
      );

      // R8
      clk_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ser_clk == ((cnt < CNT_W'(2)) || (cnt > CNT_W'(4))));

      // R6
      rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_load |-> (ser_data[LANE_N-1] == 1'b0 && ser_data[LANE_N-2] == 1'b0));
   end else begin : g_noser
      assign ser_data = '0;
      assign ser_clk  = 1'b0;
   end
endmodule

// File: tb/test_lvds10_packer.sv
`timescale 1ns/1ps
module test_lvds10_packer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt;
   logic [9:0]  r, g, b;
   logic        hs, vs, de;
   logic        pix_load;
   logic [34:0] lane_word;
   logic [4:0]  ser_data;
   logic        ser_clk;

   always #2.5 clk = ~clk;

   lvds10_packer i_lvds10_packer (
      .clk          (clk),
      .rst_n        (rst_n),
      .fmt_hi_first (fmt),
      .pix_r        (r),
      .pix_g        (g),
      .pix_b        (b),
      .pix_hs       (hs),
      .pix_vs       (vs),
      .pix_de       (de),
      .pix_load     (pix_load),
      .lane_word    (lane_word),
      .ser_data     (ser_data),
      .ser_clk      (ser_clk)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   int         m_cnt;
   logic [6:0] m_word [5];
   logic [9:0] p_r, p_g, p_b, f_r, f_g, f_b;
   logic       p_hs, p_vs, p_de, p_fmt, f_fmt;
   bit         f_valid;
   logic [9:0] rec [3];

   // col: 0 red, 1 green, 2 blue, 3 hs, 4 vs, 5 de, 6 reserved; pos is the low-first bit index
   function automatic void role(input int lane, input int slot, output int col, output int pos);
      col = 6; pos = 0;
      case (lane)
         0: if (slot < 6) begin col = 0; pos = slot; end else begin col = 1; pos = 0; end
         1: if (slot < 5) begin col = 1; pos = slot + 1; end else begin col = 2; pos = slot - 5; end
         2: if (slot < 4) begin col = 2; pos = slot + 2; end else begin col = slot - 1; pos = 0; end
         default: if (slot < 6) begin col = slot / 2; pos = (lane == 3 ? 6 : 8) + slot % 2; end
      endcase
   endfunction

   function automatic int phys(input int pos, input bit hi);
      if (!hi) return pos;
      if (pos < 6) return pos + 4;
      if (pos < 8) return pos - 4;
      return pos - 8;
   endfunction

   function automatic bit exp_bit(input int lane, input int slot, input logic [9:0] cr,
                                  input logic [9:0] cg, input logic [9:0] cb,
                                  input logic chs, input logic cvs, input logic cde, input bit hi);
      int col, pos;
      role(lane, slot, col, pos);
      case (col)
         0: return cr[phys(pos, hi)];
         1: return cg[phys(pos, hi)];
         2: return cb[phys(pos, hi)];
         3: return chs;
         4: return cvs;
         5: return cde;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input int lane, input int slot, input bit hi);
      int col, pos;
      role(lane, slot, col, pos);
      if (col == 6) return "R6";
      if (col >= 3) return "R5";
      if (hi) return "R4";
      return (lane < 3) ? "R2" : "R3";
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic pick_pixel(input int nf);
      case (nf)
         0: begin fmt = 0; r = 10'h001; g = 0; b = 0; {hs, vs, de} = 3'b000; end
         1: begin fmt = 1; r = 10'h200; g = 0; b = 0; {hs, vs, de} = 3'b000; end
         2: begin fmt = 1; r = '1; g = '1; b = '1; {hs, vs, de} = 3'b111; end
         3: begin fmt = 0; r = '1; g = '1; b = '1; {hs, vs, de} = 3'b101; end
         4: begin fmt = 0; r = 0; g = 10'h155; b = 10'h2AA; {hs, vs, de} = 3'b001; end
         default: begin
            fmt = (nf < 110) ? 1'b0 : (nf < 220) ? 1'b1 : 1'($urandom);
            r = 10'($urandom); g = 10'($urandom); b = 10'($urandom);
            hs = 1'($urandom); vs = 1'($urandom); de = 1'($urandom);
         end
      endcase
      p_r = r; p_g = g; p_b = b; p_hs = hs; p_vs = vs; p_de = de; p_fmt = fmt;
   endtask

   task automatic drive_noise();
      fmt = 1'($urandom);
      r = 10'($urandom); g = 10'($urandom); b = 10'($urandom);
      hs = 1'($urandom); vs = 1'($urandom); de = 1'($urandom);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      fmt = 0; r = 0; g = 0; b = 0; hs = 0; vs = 0; de = 0;
      repeat (4) @(negedge clk);
      // R9 reset state
      check("R9", "pix_load in reset", int'(pix_load), 0);
      check("R9", "lane_word in reset", int'(lane_word != 0), 0);
      check("R9", "ser_data in reset", int'(ser_data), 0);
      check("R9", "ser_clk in reset", int'(ser_clk), 1);
      rst_n = 1'b1;
      m_cnt = 0;
      for (int l = 0; l < 5; l++) m_word[l] = '0;
      for (int c = 0; c < 3; c++) rec[c] = '0;
      f_valid = 1'b0;
      drive_noise();
      begin
         int nf = 0;
         while (nf < 320) begin
            @(negedge clk);
            // model of the edge just passed
            if (m_cnt == 6) begin
               m_cnt = 0;
               for (int l = 0; l < 5; l++)
                  for (int s = 0; s < 7; s++)
                     m_word[l][s] = exp_bit(l, s, p_r, p_g, p_b, p_hs, p_vs, p_de, p_fmt);
               f_r = p_r; f_g = p_g; f_b = p_b; f_fmt = p_fmt; f_valid = 1'b1;
            end else begin
               m_cnt++;
            end
            // compare
            check("R1", "pix_load", int'(pix_load), int'(m_cnt == 6));
            check("R8", "ser_clk", int'(ser_clk), int'(m_cnt < 2 || m_cnt > 4));
            for (int l = 0; l < 5; l++) begin
               check((l < 3) ? (f_fmt ? "R4" : "R2") : (f_fmt ? "R4" : "R3"),
                     $sformatf("lane_word lane %0d", l), int'(lane_word[l*7 +: 7]), int'(m_word[l]));
               check({"R7 ", req_of(l, m_cnt, f_fmt)}, $sformatf("ser_data lane %0d slot %0d", l, m_cnt),
                     int'(ser_data[l]), int'(m_word[l][m_cnt]));
               if (f_valid) begin
                  int col, pos;
                  role(l, m_cnt, col, pos);
                  if (col < 3) rec[col][phys(pos, f_fmt)] = ser_data[l];
               end
            end
            if (m_cnt == 6 && f_valid) begin
               check("R10", "decoded red", int'(rec[0]), int'(f_r));
               check("R10", "decoded green", int'(rec[1]), int'(f_g));
               check("R10", "decoded blue", int'(rec[2]), int'(f_b));
               for (int c = 0; c < 3; c++) rec[c] = '0;
            end
            // stimulus: real pixel in the strobe cycle, noise otherwise (R1)
            if (m_cnt == 6) begin
               pick_pixel(nf);
               nf++;
            end else begin
               drive_noise();
            end
         end
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end
endmodule